// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel Sequencer

This block sequences one DMA channel through a chain of descriptors kept in memory. Software loads the address of the first descriptor into a writable next-descriptor register, clears the status flags and issues a start command. The channel then repeats a fixed pattern. It requests a fetch of the descriptor at its current address. It takes the link word that comes back as the new next-descriptor address. It then requests execution of that descriptor. It stops after a descriptor whose link is null.

Software steers the channel through command bits in a control register: start, stop, suspend and resume. A stop cuts the transfer off at once. A suspend lets the descriptor in flight finish first. A resume continues from the address held in the next-descriptor register. The channel reports on its progress through a status register of six flags and a read-only current-descriptor address. An interrupt output follows the flags through per-flag enables.

The datapath is reached through two request/response handshakes, one for fetch and one for execute. Each request is held high until a one-cycle done or error pulse answers it. Moving the data and decoding the descriptor fields are left to that datapath.

Top module: `chain_dma_ctrl`

## Requirements
- R1: A start command (control bit 0) takes effect only when the channel is idle and all six status bits read zero. When it takes effect, the current-descriptor register is loaded from the next-descriptor register and `fetch_req` rises on the following cycle with `fetch_addr` equal to that address. Otherwise the start command changes nothing.
- R2: A stop command (control bit 1) given while the channel is busy drops `fetch_req` and `exec_req` on the next cycle. It sets Stopped (status bit 2) and clears Active, without waiting for any response.
- R3: A suspend command (control bit 2) given while the channel is busy lets the descriptor in progress finish executing. The channel then goes idle with Suspended (bit 3) and End of Transfer set. The current-descriptor register keeps that descriptor's address, and the next-descriptor register holds its link.
- R4: A resume command (control bit 3) that takes effect loads the current-descriptor register from the next-descriptor register and fetches from it. The channel then carries on along the chain.
- R5: A resume takes effect only when the channel is idle and both Stopped and Aborted are clear. When it takes effect it clears End of Transfer, End of Chain and Suspended in the same cycle that Active rises.
- R6: The status register (address 1) is laid out as bit 0 Active, bit 1 Aborted, bit 2 Stopped, bit 3 Suspended, bit 4 End of Transfer, bit 5 End of Chain. It reads zero after reset. Active is set exactly while a fetch or execute request is outstanding, and the two requests are never high together.
- R7: When a descriptor whose fetched link is zero completes execution, End of Chain and End of Transfer are set and the channel goes idle. This takes priority over a pending suspend, so Suspended stays clear.
- R8: The current-descriptor register (address 2) reads zero after reset and ignores software writes. It changes only when a fetch begins: on start, on resume, or when the channel advances to the next descriptor.
- R9: The upper current-address register (address 3) and the upper next-address register (address 5) always read zero, and writes to them are ignored.
- R10: Status bits 1 to 5 are cleared by writing 1 to them, and bits written 0 are unchanged. Writing bit 0 has no effect.
- R11: An error pulse on `fetch_err` or `exec_err` answering an outstanding request sets Aborted, clears Active and leaves the channel idle with both requests low.
- R12: Control bits 8 to 12 are interrupt enables for Aborted, Stopped, Suspended, End of Transfer and End of Chain, in that order. They are rewritten on every control write and read back at the same positions. `irq` is high whenever some flag is set together with its enable.
- R13: Each descriptor that completes execution without error sets End of Transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_wr | input | 1 | Software register write strobe |
| sw_addr | input | 3 | Register select: 0 control, 1 status, 2 current, 3 current upper, 4 next, 5 next upper |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Read data for the selected register |
| fetch_req | output | 1 | Descriptor fetch request, held until answered |
| fetch_addr | output | 32 | Address of the descriptor to fetch |
| fetch_done | input | 1 | Fetch completed; `fetch_next` is valid |
| fetch_next | input | 32 | Link word of the fetched descriptor (zero marks the last one) |
| fetch_err | input | 1 | Fetch failed |
| exec_req | output | 1 | Execute request for the fetched descriptor |
| exec_done | input | 1 | Execution completed |
| exec_err | input | 1 | Execution failed |
| irq | output | 1 | Interrupt, any enabled flag set |

## Verification
The bench runs chains of several lengths, with errors injected on fetch and on execute at different positions. These runs expose a design that loses End of Transfer from descriptors completed before the fault, or that leaves the current-descriptor register on the wrong address. Directed cases cover the following:
- A start issued with a stale flag, which a faulty design would accept.
- A resume issued while Stopped is set, which a faulty design would act on.
- A suspend issued during a fetch, which a faulty design could turn into a halt before that descriptor executes.
- A suspend on a one-descriptor chain, where a design with the wrong priority would raise Suspended over End of Chain.

Further cases cover write-one-to-clear on single bits, the interrupt masking of each flag, and the upper and current address registers ignoring writes.

// File: rtl/chain_dma_pkg.sv
// Shared definitions for the linked-descriptor DMA channel sequencer.
// Holds the sequencer states, the status flag positions, the control bit
// positions and the register select codes. Positions listed here are part
// of the software-visible layout.
package chain_dma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_EXEC  = 2'd2
    } chan_state_e;

    localparam int NFLAG = 6;

    localparam int F_ACT = 0;
    localparam int F_ABT = 1;
    localparam int F_STP = 2;
    localparam int F_SUS = 3;
    localparam int F_EOT = 4;
    localparam int F_EOC = 5;

    localparam int C_START = 0;
    localparam int C_STOP  = 1;
    localparam int C_SUSP  = 2;
    localparam int C_RES   = 3;
    localparam int C_IE_LO = 8;

    localparam logic [2:0] A_CTRL   = 3'd0;
    localparam logic [2:0] A_STAT   = 3'd1;
    localparam logic [2:0] A_CUR    = 3'd2;
    localparam logic [2:0] A_CURHI  = 3'd3;
    localparam logic [2:0] A_NEXT   = 3'd4;
    localparam logic [2:0] A_NEXTHI = 3'd5;

endpackage

// File: rtl/chain_dma_seq.sv
// Channel sequencer: walks the descriptor chain.
// Owns the state machine, the current and next descriptor addresses and
// the pending-suspend flag. It reports status changes as one-cycle event
// pulses. Assumes each command input is a single-cycle pulse and that a
// done or error pulse arrives only while the matching request is high.
module chain_dma_seq
    import chain_dma_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_start,
    input  logic          cmd_stop,
    input  logic          cmd_susp,
    input  logic          cmd_resume,
    input  logic          status_zero,
    input  logic          resume_ok,
    input  logic          next_wr,
    input  logic [AW-1:0] next_wdata,
    output logic          fetch_req,
    output logic [AW-1:0] fetch_addr,
    input  logic          fetch_done,
    input  logic [AW-1:0] fetch_next,
    input  logic          fetch_err,
    output logic          exec_req,
    input  logic          exec_done,
    input  logic          exec_err,
    output logic          busy,
    output logic [AW-1:0] cur_addr,
    output logic [AW-1:0] next_addr,
    output logic          ev_abort,
    output logic          ev_stop,
    output logic          ev_susp,
    output logic          ev_eot,
    output logic          ev_eoc,
    output logic          ev_restart
);

    chan_state_e   state_q, state_d;
    logic [AW-1:0] cur_q, cur_d;
    logic [AW-1:0] next_q, next_d;
    logic          pend_q, pend_d;
    logic          go_start, go_resume;

    // Launch conditions seen from idle.
    assign go_start  = cmd_start && status_zero;
    assign go_resume = cmd_resume && resume_ok;

    // Next-state, address and event decode.
    always_comb begin
        state_d    = state_q;
        cur_d      = cur_q;
        next_d     = next_wr ? next_wdata : next_q;
        pend_d     = pend_q;
        ev_abort   = 1'b0;
        ev_stop    = 1'b0;
        ev_susp    = 1'b0;
        ev_eot     = 1'b0;
        ev_eoc     = 1'b0;
        ev_restart = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                pend_d = 1'b0;
                if (go_start || go_resume) begin
                    cur_d      = next_q;
                    state_d    = ST_FETCH;
                    ev_restart = go_resume && !go_start;
                end
            end
            ST_FETCH: begin
                if (cmd_susp) pend_d = 1'b1;
                if (cmd_stop) begin
                    ev_stop = 1'b1;
                    state_d = ST_IDLE;
                end else if (fetch_err) begin
                    ev_abort = 1'b1;
                    state_d  = ST_IDLE;
                end else if (fetch_done) begin
                    next_d  = fetch_next;
                    state_d = ST_EXEC;
                end
            end
            ST_EXEC: begin
                if (cmd_susp) pend_d = 1'b1;
                if (cmd_stop) begin
                    ev_stop = 1'b1;
                    state_d = ST_IDLE;
                end else if (exec_err) begin
                    ev_abort = 1'b1;
                    state_d  = ST_IDLE;
                end else if (exec_done) begin
                    ev_eot = 1'b1;
                    if (next_q == '0) begin
                        ev_eoc  = 1'b1;
                        state_d = ST_IDLE;
                    end else if (pend_q || cmd_susp) begin
                        ev_susp = 1'b1;
                        state_d = ST_IDLE;
                    end else begin
                        cur_d   = next_q;
                        state_d = ST_FETCH;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State and address registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cur_q   <= '0;
            next_q  <= '0;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cur_q   <= cur_d;
            next_q  <= next_d;
            pend_q  <= pend_d;
        end
    end

    assign fetch_req  = (state_q == ST_FETCH);
    assign exec_req   = (state_q == ST_EXEC);
    assign fetch_addr = cur_q;
    assign busy       = (state_q != ST_IDLE);
    assign cur_addr   = cur_q;
    assign next_addr  = next_q;

endmodule

// File: rtl/chain_dma_status.sv
// Status flag register.
// Hardware set events take priority over software write-one-to-clear and
// over the resume clear in the same cycle. The Active bit is not stored:
// it is taken from the sequencer's busy signal. Assumes the set and clear
// event vectors use the flag positions of the package.
module chain_dma_status
    import chain_dma_pkg::*;
#(
    parameter int NF = NFLAG
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          busy,
    input  logic [NF-1:1] hw_set,
    input  logic [NF-1:1] hw_clr,
    input  logic [NF-1:1] sw_clr,
    output logic [NF-1:0] status,
    output logic          status_zero,
    output logic          resume_ok
);

    logic [NF-1:1] flags_q;

    // Flag update: clear first, then apply hardware sets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= (flags_q & ~sw_clr & ~hw_clr) | hw_set;
        end
    end

    assign status      = {flags_q, busy};
    assign status_zero = (flags_q == '0) && !busy;
    assign resume_ok   = !flags_q[F_STP] && !flags_q[F_ABT] && !busy;

endmodule

// File: rtl/chain_dma_irq.sv
// Interrupt enable register and interrupt combine.
// Holds one enable per stored status flag and raises irq while any flag is
// set together with its enable. Assumes flag i pairs with enable i-1.
module chain_dma_irq #(
    parameter int NF = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ie_wr,
    input  logic [NF-2:0] ie_wdata,
    input  logic [NF-1:1] flags,
    output logic [NF-2:0] ie,
    output logic          irq
);

    logic [NF-2:0] ie_q;
    logic [NF-2:0] hit;

    // Enable register, rewritten on each control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q <= '0;
        end else if (ie_wr) begin
            ie_q <= ie_wdata;
        end
    end

    // Per-flag masking.
    for (genvar g = 0; g < NF - 1; g++) begin : g_mask
        assign hit[g] = flags[g+1] && ie_q[g];
    end

    assign ie  = ie_q;
    assign irq = |hit;

endmodule

// File: rtl/chain_dma_ctrl.sv
// Top of the linked-descriptor DMA channel sequencer.
// Decodes software writes into commands, status clears, enable and
// next-address updates, muxes read data, and wires the sequencer, the
// status flags and the interrupt logic together. Assumes one register
// access per cycle and AW no wider than DW.
module chain_dma_ctrl
    import chain_dma_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sw_wr,
    input  logic [2:0]    sw_addr,
    input  logic [DW-1:0] sw_wdata,
    output logic [DW-1:0] sw_rdata,
    output logic          fetch_req,
    output logic [AW-1:0] fetch_addr,
    input  logic          fetch_done,
    input  logic [AW-1:0] fetch_next,
    input  logic          fetch_err,
    output logic          exec_req,
    input  logic          exec_done,
    input  logic          exec_err,
    output logic          irq
);

    localparam int NF  = NFLAG;
    localparam int NIE = NF - 1;

    logic          ctrl_wr, stat_wr, next_wr;
    logic          cmd_start, cmd_stop, cmd_susp, cmd_resume;
    logic          busy, status_zero, resume_ok;
    logic          ev_abort, ev_stop, ev_susp, ev_eot, ev_eoc, ev_restart;
    logic [NF-1:1] hw_set, hw_clr, sw_clr;
    logic [NF-1:0] status_w;
    logic [NIE-1:0] ie_w;
    logic [AW-1:0] cur_w, next_w;

    // Write decode.
    assign ctrl_wr    = sw_wr && (sw_addr == A_CTRL);
    assign stat_wr    = sw_wr && (sw_addr == A_STAT);
    assign next_wr    = sw_wr && (sw_addr == A_NEXT);
    assign cmd_start  = ctrl_wr && sw_wdata[C_START];
    assign cmd_stop   = ctrl_wr && sw_wdata[C_STOP];
    assign cmd_susp   = ctrl_wr && sw_wdata[C_SUSP];
    assign cmd_resume = ctrl_wr && sw_wdata[C_RES];
    assign sw_clr     = stat_wr ? sw_wdata[NF-1:1] : '0;

    // Map sequencer events onto flag set and clear vectors.
    always_comb begin
        hw_set        = '0;
        hw_clr        = '0;
        hw_set[F_ABT] = ev_abort;
        hw_set[F_STP] = ev_stop;
        hw_set[F_SUS] = ev_susp;
        hw_set[F_EOT] = ev_eot;
        hw_set[F_EOC] = ev_eoc;
        hw_clr[F_EOT] = ev_restart;
        hw_clr[F_EOC] = ev_restart;
        hw_clr[F_SUS] = ev_restart;
    end

    chain_dma_seq #(.AW(AW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_start  (cmd_start),
        .cmd_stop   (cmd_stop),
        .cmd_susp   (cmd_susp),
        .cmd_resume (cmd_resume),
        .status_zero(status_zero),
        .resume_ok  (resume_ok),
        .next_wr    (next_wr),
        .next_wdata (sw_wdata[AW-1:0]),
        .fetch_req  (fetch_req),
        .fetch_addr (fetch_addr),
        .fetch_done (fetch_done),
        .fetch_next (fetch_next),
        .fetch_err  (fetch_err),
        .exec_req   (exec_req),
        .exec_done  (exec_done),
        .exec_err   (exec_err),
        .busy       (busy),
        .cur_addr   (cur_w),
        .next_addr  (next_w),
        .ev_abort   (ev_abort),
        .ev_stop    (ev_stop),
        .ev_susp    (ev_susp),
        .ev_eot     (ev_eot),
        .ev_eoc     (ev_eoc),
        .ev_restart (ev_restart)
    );

    chain_dma_status #(.NF(NF)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy       (busy),
        .hw_set     (hw_set),
        .hw_clr     (hw_clr),
        .sw_clr     (sw_clr),
        .status     (status_w),
        .status_zero(status_zero),
        .resume_ok  (resume_ok)
    );

    chain_dma_irq #(.NF(NF)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .ie_wr   (ctrl_wr),
        .ie_wdata(sw_wdata[C_IE_LO +: NIE]),
        .flags   (status_w[NF-1:1]),
        .ie      (ie_w),
        .irq     (irq)
    );

    // Read data mux; command bits and upper address registers read zero.
    always_comb begin
        sw_rdata = '0;
        unique case (sw_addr)
            A_CTRL:  sw_rdata[C_IE_LO +: NIE] = ie_w;
            A_STAT:  sw_rdata[NF-1:0] = status_w;
            A_CUR:   sw_rdata[AW-1:0] = cur_w;
            A_NEXT:  sw_rdata[AW-1:0] = next_w;
            default: sw_rdata = '0;
        endcase
    end

endmodule

// File: rtl/chain_dma_ctrl_chk.sv
// Property checker for chain_dma_ctrl, attached by bind.
// Watches the software write port, the handshakes, the status flags and
// the current address. Assumes a synchronous active-low reset.
module chain_dma_ctrl_chk #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sw_wr,
    input logic [2:0]    sw_addr,
    input logic [DW-1:0] sw_wdata,
    input logic          fetch_req,
    input logic          fetch_err,
    input logic          exec_req,
    input logic          irq,
    input logic [5:0]    status,
    input logic [AW-1:0] cur_addr
);

    logic ctl_wr, start_wr, stop_wr;
    assign ctl_wr   = sw_wr && (sw_addr == 3'd0);
    assign start_wr = ctl_wr && sw_wdata[0];
    assign stop_wr  = ctl_wr && sw_wdata[1];

    p_start_blocked_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (start_wr && !status[0] && (status != 6'd0)) |=> !fetch_req);

    p_stop_halts_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_wr && (fetch_req || exec_req)) |=> (!fetch_req && !exec_req && status[2]));

    p_req_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(fetch_req && exec_req));

    p_active_tracks_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        status[0] == (fetch_req || exec_req));

    p_cur_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        exec_req |=> ($stable(cur_addr) || fetch_req));

    p_fetch_err_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && fetch_err && !stop_wr) |=> (status[1] && !fetch_req && !exec_req));

    p_irq_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (status[5:1] == 5'd0) |-> !irq);

endmodule

bind chain_dma_ctrl chain_dma_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sw_wr    (sw_wr),
    .sw_addr  (sw_addr),
    .sw_wdata (sw_wdata),
    .fetch_req(fetch_req),
    .fetch_err(fetch_err),
    .exec_req (exec_req),
    .irq      (irq),
    .status   (status_w),
    .cur_addr (cur_w)
);

// File: tb/chain_dma_ctrl_bench.sv
`timescale 1ns/1ps
module chain_dma_ctrl_bench;

    localparam logic [31:0] IE_ALL = 32'h0000_1F00;

    typedef struct packed {
        logic [31:0] base;
        logic [7:0]  len;
        logic [7:0]  ferr;
        logic [7:0]  xerr;
        logic [5:0]  st;
        logic [7:0]  ex;
        logic [31:0] cur;
    } vec_t;

    // base, chain length, fetch-error index, exec-error index,
    // expected status, expected executions, expected current address
    localparam vec_t VECS [5] = '{
        '{32'h0000_1000, 8'd1, 8'hFF, 8'hFF, 6'h30, 8'd1, 32'h0000_1000},
        '{32'h0000_2000, 8'd4, 8'hFF, 8'hFF, 6'h30, 8'd4, 32'h0000_2060},
        '{32'h0000_3000, 8'd3, 8'd1,  8'hFF, 6'h12, 8'd1, 32'h0000_3020},
        '{32'h0000_4000, 8'd5, 8'hFF, 8'd2,  6'h12, 8'd2, 32'h0000_4040},
        '{32'h0000_5000, 8'd2, 8'd0,  8'hFF, 6'h02, 8'd0, 32'h0000_5000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_wr = 1'b0;
    logic [2:0]  sw_addr = 3'd0;
    logic [31:0] sw_wdata = '0;
    logic [31:0] sw_rdata;
    logic        fetch_req, exec_req, irq;
    logic [31:0] fetch_addr;
    logic        fetch_done = 1'b0, fetch_err = 1'b0;
    logic [31:0] fetch_next = '0;
    logic        exec_done = 1'b0, exec_err = 1'b0;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    logic [31:0] tb_base = '0;
    int tb_len = 1, tb_ferr = 255, tb_xerr = 255;
    int lat = 2, fcnt = 0, xcnt = 0, cur_idx = 0, execs = 0;

    always #2.5 clk = ~clk;

    chain_dma_ctrl u_chain_dma_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_wr     (sw_wr),
        .sw_addr   (sw_addr),
        .sw_wdata  (sw_wdata),
        .sw_rdata  (sw_rdata),
        .fetch_req (fetch_req),
        .fetch_addr(fetch_addr),
        .fetch_done(fetch_done),
        .fetch_next(fetch_next),
        .fetch_err (fetch_err),
        .exec_req  (exec_req),
        .exec_done (exec_done),
        .exec_err  (exec_err),
        .irq       (irq)
    );

    // Datapath model: answers each request after lat cycles.
    always @(negedge clk) begin
        int idx;
        fetch_done = 1'b0; fetch_err = 1'b0;
        exec_done  = 1'b0; exec_err  = 1'b0;
        if (fetch_req) begin
            if (fcnt >= lat) begin
                fcnt = 0;
                idx = int'((fetch_addr - tb_base) >> 5);
                if (idx == tb_ferr) fetch_err = 1'b1;
                else begin
                    fetch_done = 1'b1;
                    cur_idx = idx;
                    fetch_next = (idx + 1 < tb_len) ? fetch_addr + 32'd32 : 32'd0;
                end
            end else fcnt++;
        end else fcnt = 0;
        if (exec_req) begin
            if (xcnt >= lat) begin
                xcnt = 0;
                if (cur_idx == tb_xerr) exec_err = 1'b1;
                else begin
                    exec_done = 1'b1;
                    execs++;
                end
            end else xcnt++;
        end else xcnt = 0;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic sw_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        sw_wr = 1'b1; sw_addr = a; sw_wdata = d;
        @(negedge clk);
        sw_wr = 1'b0;
    endtask

    task automatic sw_read(input logic [2:0] a, output logic [31:0] d);
        sw_addr = a;
        #1;
        d = sw_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int k = 0; k < 2000; k++) begin
            @(negedge clk);
            sw_read(3'd1, s);
            if (!s[0]) break;
        end
    endtask

    task automatic set_chain(input logic [31:0] b, input int n, input int fe, input int xe);
        tb_base = b; tb_len = n; tb_ferr = fe; tb_xerr = xe;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        sw_read(3'd1, r); chk("R6 status after reset", r, 32'h0);
        sw_read(3'd2, r); chk("R8 current address after reset", r, 32'h0);
        sw_read(3'd0, r); chk("R12 enables after reset", r, 32'h0);
        chk("R6 fetch_req after reset", {31'd0, fetch_req}, 32'h0);
        chk("R12 irq after reset", {31'd0, irq}, 32'h0);

        // Table of chains
        for (int i = 0; i < 5; i++) begin
            set_chain(VECS[i].base, int'(VECS[i].len), int'(VECS[i].ferr), int'(VECS[i].xerr));
            execs = 0;
            sw_write(3'd1, 32'h3E);
            sw_write(3'd4, VECS[i].base);
            sw_write(3'd0, IE_ALL | 32'h1);
            wait_idle();
            sw_read(3'd1, r); chk($sformatf("R7 R11 R13 vec%0d status", i), r, {26'd0, VECS[i].st});
            sw_read(3'd2, r); chk($sformatf("R1 R4 R8 vec%0d current", i), r, VECS[i].cur);
            chk($sformatf("R13 vec%0d executions", i), execs, {24'd0, VECS[i].ex});
            chk($sformatf("R12 vec%0d irq", i), {31'd0, irq}, 32'h1);
        end

        // Write-one-to-clear
        set_chain(32'h8000, 1, 255, 255);
        sw_write(3'd1, 32'h3E);
        sw_write(3'd4, 32'h8000);
        sw_write(3'd0, IE_ALL | 32'h1);
        wait_idle();
        sw_write(3'd1, 32'h10);
        sw_read(3'd1, r); chk("R10 clear only End of Transfer", r, 32'h20);
        sw_write(3'd1, 32'h01);
        sw_read(3'd1, r); chk("R10 Active bit write ignored", r, 32'h20);

        // Start ignored while a flag remains
        sw_write(3'd0, IE_ALL | 32'h1);
        chk("R1 start ignored with flag set", {31'd0, fetch_req}, 32'h0);
        sw_read(3'd1, r); chk("R1 status unchanged after ignored start", r, 32'h20);

        // Interrupt masking
        sw_write(3'd0, 32'h0);
        chk("R12 irq masked", {31'd0, irq}, 32'h0);
        sw_write(3'd0, 32'h1000);
        chk("R12 irq End of Chain enable", {31'd0, irq}, 32'h1);
        sw_read(3'd0, r); chk("R12 enable readback", r, 32'h1000);
        sw_write(3'd0, 32'h0100);
        chk("R12 irq abort enable only", {31'd0, irq}, 32'h0);

        // Upper registers and read-only current address
        sw_write(3'd5, 32'hFFFF_FFFF);
        sw_write(3'd3, 32'hFFFF_FFFF);
        sw_read(3'd3, r); chk("R9 upper current reads zero", r, 32'h0);
        sw_read(3'd5, r); chk("R9 upper next reads zero", r, 32'h0);
        sw_write(3'd2, 32'h1234);
        sw_read(3'd2, r); chk("R8 current ignores writes", r, 32'h8000);

        // Stop during first fetch
        lat = 6;
        execs = 0;
        set_chain(32'h9000, 4, 255, 255);
        sw_write(3'd1, 32'h3E);
        sw_write(3'd4, 32'h9000);
        sw_write(3'd0, IE_ALL | 32'h1);
        chk("R1 fetch_addr after start", fetch_addr, 32'h9000);
        sw_write(3'd0, IE_ALL | 32'h2);
        chk("R2 requests drop after stop", {30'd0, fetch_req, exec_req}, 32'h0);
        sw_read(3'd1, r); chk("R2 status after stop", r, 32'h04);
        chk("R2 no execution after stop", execs, 32'd0);

        // Resume gated by Stopped
        sw_write(3'd0, IE_ALL | 32'h8);
        chk("R5 resume ignored while stopped", {31'd0, fetch_req}, 32'h0);
        sw_read(3'd1, r); chk("R5 status unchanged after gated resume", r, 32'h04);

        // Suspend then resume
        lat = 4;
        execs = 0;
        set_chain(32'h6000, 4, 255, 255);
        sw_write(3'd1, 32'h3E);
        sw_write(3'd4, 32'h6000);
        sw_write(3'd0, IE_ALL | 32'h1);
        sw_write(3'd0, IE_ALL | 32'h4);
        wait_idle();
        sw_read(3'd1, r); chk("R3 status after suspend", r, 32'h18);
        chk("R3 one descriptor finished", execs, 32'd1);
        sw_read(3'd2, r); chk("R3 current held", r, 32'h6000);
        sw_read(3'd4, r); chk("R3 next holds link", r, 32'h6020);
        sw_write(3'd0, IE_ALL | 32'h8);
        sw_read(3'd1, r); chk("R5 resume clears flags", r, 32'h01);
        chk("R4 resume fetch address", fetch_addr, 32'h6020);
        wait_idle();
        sw_read(3'd1, r); chk("R4 status at chain end", r, 32'h30);
        chk("R4 total executions", execs, 32'd4);
        sw_read(3'd2, r); chk("R4 final current", r, 32'h6060);

        // Suspend on the terminal descriptor
        execs = 0;
        set_chain(32'h7000, 1, 255, 255);
        sw_write(3'd1, 32'h3E);
        sw_write(3'd4, 32'h7000);
        sw_write(3'd0, IE_ALL | 32'h1);
        sw_write(3'd0, IE_ALL | 32'h4);
        wait_idle();
        sw_read(3'd1, r); chk("R7 terminal wins over suspend", r, 32'h30);

        // Execute error
        execs = 0;
        set_chain(32'hA000, 2, 255, 0);
        sw_write(3'd1, 32'h3E);
        sw_write(3'd4, 32'hA000);
        sw_write(3'd0, IE_ALL | 32'h1);
        wait_idle();
        sw_read(3'd1, r); chk("R11 execute error aborts", r, 32'h02);
        chk("R11 requests low after error", {30'd0, fetch_req, exec_req}, 32'h0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule